// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns host-written characters into an asynchronous serial stream. A character written by the host goes into a holding register. It moves to a separate shift register as soon as that register is free, so the host can queue the next character while the current one is still on the line. The bit timing comes from a transmit clock enable, `txc_tick`: one pulse for each falling edge of the transmit clock. The bit period is 1, 16 or 64 of these ticks, chosen by the mode inputs.

The mode inputs select the character length (5 to 8 bits), optional even or odd parity, and one, one-and-a-half or two stop bits. Mode inputs should be held stable while a frame is on the line.

Transmission runs only while the transmit-enable command is set and the active-low clear-to-send input is low. A character that is already shifting still completes when either condition drops. A separate break command holds the line low. Two flags report progress: `hold_empty` says the holding register can take a character, and `tx_empty` says nothing at all is left to send. The gated `tx_ready` pin combines the holding state with the enable and clear-to-send conditions.

Top module: `async_tx_dbuf`

## Requirements
- R1: After reset, `txd` is high and `hold_empty` and `tx_empty` are both high.
- R2: A frame is one low start bit, then 5+`len_sel` data bits sent LSB first, then the optional parity bit, then the high stop bits. Data bits above the selected length are not sent.
- R3: With `par_en`=1, the parity bit makes the count of ones in the data bits plus the parity bit even when `par_odd`=0, and odd when `par_odd`=1.
- R4: Each bit lasts 1, 16 or 64 `txc_tick` pulses for `rate_sel` = 00, 01 or 10 (11 acts as 10). The line changes on the tick that starts a bit.
- R5: `stop_sel`=00 sends one stop bit and 10 sends two. With 01, the x16 and x64 rates send one full stop bit followed by one half-length stop bit. At the x1 rate, 01 sends a single stop bit.
- R6: The held character moves to the shifter on a tick when the shifter is idle or is finishing its last bit. `hold_empty` rises at that moment, and a queued character starts on the tick right after the previous last stop bit, with no idle bit between.
- R7: `tx_empty` is high only while both registers are empty. A write clears it at the next clock.
- R8: `tx_ready` equals `hold_empty` AND `tx_enable` AND NOT `cts_n`. `hold_empty` itself ignores the enable and clear-to-send conditions.
- R9: Dropping `tx_enable` or raising `cts_n` lets the frame in progress finish. A character written while disabled waits with the line at mark and is sent once transmission is enabled again.
- R10: While `send_break` is high, `txd` is low whatever the transmitter state.
- R11: A write while the holding register is full is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc_tick | input | 1 | One-cycle pulse per transmit clock falling edge |
| rate_sel | input | 2 | Ticks per bit: 00 x1, 01 x16, 10/11 x64 |
| len_sel | input | 2 | Character length 5+len_sel |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| stop_sel | input | 2 | 00 one, 01 one and a half, 10/11 two stop bits |
| tx_enable | input | 1 | Transmit enable command |
| send_break | input | 1 | Force the line low |
| cts_n | input | 1 | Clear to send, active low |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write character |
| txd | output | 1 | Serial output |
| tx_ready | output | 1 | Gated ready pin |
| hold_empty | output | 1 | Holding register empty (ungated) |
| tx_empty | output | 1 | Both registers empty |

## Verification
The bench checks every bit of each frame at tick resolution, across character lengths, parity senses, stop settings and all three rates. A design with an off-by-one bit period, reversed bit order or inverted parity would show a wrong level at some tick.

Two characters are sent back to back with 1.5 stop bits at x16. A transmitter that used a full-length last stop bit, or that inserted an idle bit between frames, would start the second frame late.

Clear-to-send is held high while a character waits, and the enable is dropped in the middle of a frame. A design that sent the waiting character too early, or cut off the frame in progress, would be caught. Writes into a full holding register and break forcing are also checked at the output.

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txc_tick,
  input  logic [1:0]        rate_sel,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic              tx_enable,
  input  logic              send_break,
  input  logic              cts_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_ready,
  output logic              hold_empty,
  output logic              tx_empty
);
  localparam int BITS_W = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  logic               hold_full;
  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  bits_left;
  logic [CNT_W-1:0]   tick_cnt;
  logic               busy, txd_q, half_q;

  logic [CNT_W-1:0]   full_rl, half_rl;
  logic [3:0]         nd;
  logic [DATA_W-1:0]  masked;
  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits;
  logic               two_stop, half_last, go, last_done, start_ok;

  assign full_rl = (rate_sel == 2'b00) ? CNT_W'(0) :
                   (rate_sel == 2'b01) ? CNT_W'(15) : CNT_W'(63);
  assign half_rl = (rate_sel == 2'b01) ? CNT_W'(7) : CNT_W'(31);
  assign nd = 4'd5 + {2'b00, len_sel};
  assign half_last = (stop_sel == 2'b01) && (rate_sel != 2'b00);
  assign two_stop = stop_sel[1] || half_last;

  always_comb begin
    masked = '0;
    frame = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nd)) begin
        masked[i] = hold_q[i];
        frame[i] = hold_q[i];
      end
    end
    if (par_en) frame[nd] = (^masked) ^ par_odd;
  end

  assign nbits = BITS_W'(nd) + BITS_W'(par_en) + (two_stop ? BITS_W'(2) : BITS_W'(1));

  assign go = tx_enable && !cts_n;
  assign last_done = busy && (tick_cnt == '0) && (bits_left == '0);
  assign start_ok = txc_tick && hold_full && go && (!busy || last_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hold_full <= 1'b0;
      sh_q <= '1;
      bits_left <= '0;
      tick_cnt <= '0;
      busy <= 1'b0;
      txd_q <= 1'b1;
      half_q <= 1'b0;
    end else begin
      if (wr_stb && !hold_full) begin
        hold_q <= wr_data;
        hold_full <= 1'b1;
      end else if (start_ok) begin
        hold_full <= 1'b0;
      end

      if (start_ok) begin
        busy <= 1'b1;
        txd_q <= 1'b0;
        sh_q <= frame;
        bits_left <= nbits;
        tick_cnt <= full_rl;
        half_q <= half_last;
      end else if (txc_tick && busy) begin
        if (tick_cnt != '0) begin
          tick_cnt <= tick_cnt - 1'b1;
        end else if (bits_left != '0) begin
          txd_q <= sh_q[0];
          sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
          tick_cnt <= (bits_left == BITS_W'(1) && half_q) ? half_rl : full_rl;
        end else begin
          busy <= 1'b0;
          txd_q <= 1'b1;
        end
      end
    end
  end

  assign txd = send_break ? 1'b0 : (busy ? txd_q : 1'b1);
  assign hold_empty = !hold_full;
  assign tx_empty = !hold_full && !busy;
  assign tx_ready = hold_empty && go;
endmodule

module async_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic txc_tick,
  input logic wr_stb,
  input logic tx_enable,
  input logic cts_n,
  input logic send_break,
  input logic txd,
  input logic tx_ready,
  input logic hold_empty,
  input logic tx_empty
);
  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (hold_empty && tx_enable && !cts_n));
  assert_empty_implies_hold_R7: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> hold_empty);
  assert_break_low_R10: assert property (@(posedge clk) disable iff (rst)
    send_break |-> !txd);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !send_break) |-> txd);
  assert_write_fills_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && hold_empty) |=> !hold_empty);
  assert_hold_moves_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!txc_tick && !wr_stb) |=> $stable(hold_empty));
  assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && hold_empty) |=> !tx_empty);
endmodule

bind async_tx_dbuf async_tx_dbuf_chk chk_i (
  .clk(clk), .rst(rst), .txc_tick(txc_tick), .wr_stb(wr_stb),
  .tx_enable(tx_enable), .cts_n(cts_n), .send_break(send_break),
  .txd(txd), .tx_ready(tx_ready), .hold_empty(hold_empty), .tx_empty(tx_empty)
);

// File: tb/async_tx_dbuf_tb.sv
module async_tx_dbuf_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txc_tick = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic [1:0] len_sel = 2'b11;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic [1:0] stop_sel = 2'b00;
  logic tx_enable = 1'b1;
  logic send_break = 1'b0;
  logic cts_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, tx_ready, hold_empty, tx_empty;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  async_tx_dbuf dut_i (
    .clk(clk), .rst(rst), .txc_tick(txc_tick), .rate_sel(rate_sel),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .tx_enable(tx_enable), .send_break(send_break), .cts_n(cts_n),
    .wr_stb(wr_stb), .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // fields: data[15:8] len[7:6] par[5] odd[4] stop[3:2] rate[1:0]
  localparam logic [15:0] VEC [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0},
    {8'h3C, 2'd3, 1'b1, 1'b0, 2'd2, 2'd0},
    {8'h3C, 2'd3, 1'b1, 1'b1, 2'd0, 2'd1},
    {8'h1F, 2'd0, 1'b1, 1'b0, 2'd0, 2'd0},
    {8'h2A, 2'd1, 1'b1, 1'b1, 2'd1, 2'd0},
    {8'h55, 2'd2, 1'b0, 1'b0, 2'd2, 2'd2},
    {8'h81, 2'd3, 1'b1, 1'b0, 2'd1, 2'd1},
    {8'hFF, 2'd0, 1'b1, 1'b1, 2'd0, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) txc_tick = 1'b1;
    @(negedge clk) txc_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
    @(negedge clk) wr_stb = 1'b0;
  endtask

  task automatic set_mode(input logic [15:0] v);
    len_sel = v[7:6]; par_en = v[5]; par_odd = v[4]; stop_sel = v[3:2]; rate_sel = v[1:0];
  endtask

  // checks a whole frame tick by tick; started=1 means the start tick already passed
  task automatic check_frame(input logic [15:0] v, input bit started, input bit idle_after, input string tag);
    logic [15:0] bits;
    int nb, fac, nd, bad, first_bad_tick;
    logic [7:0] d;
    logic pbit;
    bit half;
    d = v[15:8];
    fac = (v[1:0] == 2'd0) ? 1 : (v[1:0] == 2'd1) ? 16 : 64;
    nd = 5 + int'(v[7:6]);
    half = (v[3:2] == 2'd1) && (v[1:0] != 2'd0);
    bits = '1;
    bits[0] = 1'b0;
    nb = 1;
    pbit = v[4];
    for (int i = 0; i < nd; i++) begin
      bits[nb] = d[i];
      pbit = pbit ^ d[i];
      nb++;
    end
    if (v[5]) begin bits[nb] = pbit; nb++; end
    nb++;
    if (v[3:2] >= 2'd2 || half) nb++;
    bad = 0;
    first_bad_tick = -1;
    for (int b = 0; b < nb; b++) begin
      int dur;
      dur = (b == nb - 1 && half) ? fac / 2 : fac;
      if (b == 0 && started) dur = dur - 1;
      for (int t = 0; t < dur; t++) begin
        tick();
        if (txd !== bits[b]) begin
          if (bad == 0) first_bad_tick = b;
          bad++;
        end
      end
    end
    chk(bad == 0, {tag, " frame bits (first bad bit index as actual)"}, first_bad_tick, -1);
    if (idle_after) begin
      tick();
      chk(txd === 1'b1 && tx_empty === 1'b1, {tag, " idle after frame"}, {txd, tx_empty}, 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(hold_empty === 1'b1 && tx_empty === 1'b1, "R1 flags after reset", {hold_empty, tx_empty}, 3);
    chk(tx_ready === 1'b1, "R8 ready with enable and cts low", tx_ready, 1);

    // R2 R3 R4 R5 table walk
    for (int k = 0; k < 8; k++) begin
      set_mode(VEC[k]);
      write(VEC[k][15:8]);
      if (k == 0) begin
        chk(tx_empty === 1'b0 && hold_empty === 1'b0, "R7 flags fall on write", {tx_empty, hold_empty}, 0);
        chk(tx_ready === 1'b0, "R8 ready low when holding full", tx_ready, 0);
      end
      check_frame(VEC[k], 1'b0, 1'b1, $sformatf("R2 R3 R4 R5 vector %0d", k));
    end

    // R6 R5 R11: back to back with 1.5 stop at x16
    set_mode({8'h00, 2'd3, 1'b0, 1'b0, 2'd1, 2'd1});
    write(8'h96);
    tick();
    chk(txd === 1'b0 && hold_empty === 1'b1 && tx_empty === 1'b0, "R6 transfer on start tick",
        {txd, hold_empty, tx_empty}, 2);
    write(8'h4B);
    write(8'hFF);
    chk(hold_empty === 1'b0, "R6 second char held", hold_empty, 0);
    check_frame({8'h96, 2'd3, 1'b0, 1'b0, 2'd1, 2'd1}, 1'b1, 1'b0, "R6 R5 first frame");
    check_frame({8'h4B, 2'd3, 1'b0, 1'b0, 2'd1, 2'd1}, 1'b0, 1'b1, "R11 R5 second frame");

    // R9 R8: clear to send high while a character waits
    set_mode({8'h00, 2'd3, 1'b1, 1'b0, 2'd0, 2'd0});
    cts_n = 1'b1;
    @(negedge clk);
    chk(tx_ready === 1'b0 && hold_empty === 1'b1, "R8 cts high gates pin only", {tx_ready, hold_empty}, 1);
    write(8'hC3);
    begin
      int hi;
      hi = 0;
      for (int t = 0; t < 20; t++) begin
        tick();
        if (txd === 1'b1 && tx_empty === 1'b0) hi++;
      end
      chk(hi == 20, "R9 waits at mark while disabled", hi, 20);
    end
    cts_n = 1'b0;
    check_frame({8'hC3, 2'd3, 1'b1, 1'b0, 2'd0, 2'd0}, 1'b0, 1'b1, "R9 sent after enable");

    // R9: disable during a frame
    write(8'h5A);
    tick();
    chk(txd === 1'b0, "R9 start before disable", txd, 0);
    tx_enable = 1'b0;
    check_frame({8'h5A, 2'd3, 1'b1, 1'b0, 2'd0, 2'd0}, 1'b1, 1'b1, "R9 frame finishes after disable");
    chk(tx_ready === 1'b0 && hold_empty === 1'b1, "R8 enable low gates pin", {tx_ready, hold_empty}, 1);
    tx_enable = 1'b1;

    // R10 break
    @(negedge clk) send_break = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R10 break forces low", txd, 0);
    tick();
    chk(txd === 1'b0, "R10 break held across tick", txd, 0);
    @(negedge clk) send_break = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R10 mark after break released", txd, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule